// File: doc/BRIEF.md
# Paired-Channel Coincidence Trigger

This block sits between the per-channel discriminators and the rest of a multichannel pulse processor, and decides which hits go forward. Each channel's hit is stretched into a shaped trigger that lasts a programmed number of clock ticks. The block does this with a small per-channel state machine that has two states. In SH_IDLE the channel has no stretch running. In SH_HOLD a countdown is running. A hit moves SH_IDLE to SH_HOLD (the load transition) when the stretch is longer than one tick. A hit seen in SH_HOLD reloads the countdown (the restart transition). When the countdown reaches its last tick, SH_HOLD returns to SH_IDLE (the expire transition).

Channels are grouped in couples: channels 2k and 2k+1 form couple k. The two shaped triggers of a couple are combined into one couple trigger. A channel in free mode accepts every enabled hit. A channel in coincidence mode accepts a hit only when its validation signal is present in that same cycle. The validation signal comes from one of three places: the partner channel, any couple, or the couples picked by a per-couple mask. Configuration is written through a single-cycle write port.

Top module: `pair_coinc_trigger`

## Requirements
- R1: Reset behaviour. After reset, all accept outputs are low and no stretch is running. The configuration resets to these values: every channel in mode 00 and enabled, width 0, couple combine 000, validation source 000, all masks 0.
- R2: A channel whose 2-bit mode is any code other than 01 (free mode) raises its accept bit for exactly one cycle. This happens in the cycle after each enabled hit.
- R3: When a channel's disable bit is set, its hits are ignored. They produce no accept and no shaped trigger, so they cannot validate any other channel.
- R4: Take a hit in cycle t with width W ≥ 1. The shaped trigger is active in cycles t through t+W-1 and inactive from t+W. With W = 0 it is active only in cycle t.
- R5: A new hit while the shaped trigger is active restarts the full count, using the width in force at that new hit. A running count is not cut short by a width write.
- R6: A channel with mode 01 (coincidence) accepts a hit only if its validation signal is active in the hit cycle. A validating hit in the same cycle counts.
- R7: The 3-bit validation source of the channel's couple selects the signal. Code 000 uses the partner channel's shaped trigger. Code 111 uses the OR of all couple triggers. Code 101 uses the masked couple triggers. Any other code gives no validation.
- R8: The 3-bit couple combine field sets the couple trigger. Code 000 is the AND of both shaped triggers. Code 001 is the OR. Code 101 is the even channel only. Code 110 is the odd channel only. Any other code holds the couple trigger low.
- R9: Bit j of couple c's validation mask lets couple j's trigger validate couple c when the source is 101. A cleared bit blocks couple j.
- R10: A write with cfg_we high updates configuration from the next clock. The field is chosen by cfg_sel. Code 0 addresses channel cfg_idx: bits [1:0] are the mode and bit 2 is the disable bit. Code 1 addresses channel cfg_idx: bits [WIDTH_W-1:0] are the width. Code 2 addresses couple cfg_idx/2: bits [2:0] are the combine field and bits [6:4] are the validation source. Code 3 addresses couple cfg_idx/2: bits [NUM_CPL-1:0] are the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NUM_CH | Discriminator hit per channel, one bit per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field selector for the write |
| cfg_idx | input | $clog2(NUM_CH) | Channel index; couple index is cfg_idx/2 |
| cfg_wdata | input | 16 | Write data |
| acc_o | output | NUM_CH | One-cycle accept pulse per channel, one cycle after the hit |

## Verification
The bench builds the block with NUM_CH = 4, so there are two couples, and keeps the default 10-bit width field. Two couples are enough for one couple to validate the other through its mask. They also allow a couple to validate itself, and let the any-couple OR be checked against a silent couple. Widths of 0, 1, 4 and 5 ticks keep every window edge, retrigger extension and mid-flight width write within a few cycles. Every combine code and validation code can then be swept in short directed runs.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    typedef enum logic {SH_IDLE, SH_HOLD} sh_state_e;

    localparam logic [1:0] MODE_COINC = 2'b01;

    localparam logic [2:0] CMB_AND  = 3'b000;
    localparam logic [2:0] CMB_OR   = 3'b001;
    localparam logic [2:0] CMB_EVEN = 3'b101;
    localparam logic [2:0] CMB_ODD  = 3'b110;

    localparam logic [2:0] VAL_PARTNER = 3'b000;
    localparam logic [2:0] VAL_MASK    = 3'b101;
    localparam logic [2:0] VAL_ANY     = 3'b111;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_WIDTH = 2'd1;
    localparam logic [1:0] SEL_CPL   = 2'd2;
    localparam logic [1:0] SEL_MASK  = 2'd3;
endpackage

// File: rtl/ctp_shaper.sv
module ctp_shaper import ctp_pkg::*; #(
    parameter int WIDTH_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [WIDTH_W-1:0] width,
    output logic               shaped
);
    sh_state_e          state_q, state_d;
    logic [WIDTH_W-1:0] cnt_q, cnt_d;
    logic [WIDTH_W-1:0] load;

    assign load = (width == '0) ? '0 : width - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SH_IDLE: begin
                if (fire && load != '0) begin
                    state_d = SH_HOLD;
                    cnt_d   = load;
                end
            end
            SH_HOLD: begin
                if (fire) begin
                    cnt_d = load;
                    if (load == '0) state_d = SH_IDLE;
                end else if (cnt_q == WIDTH_W'(1)) begin
                    state_d = SH_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        shaped = fire || (state_q == SH_HOLD);
    end

    // R4
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && width > WIDTH_W'(1)) |=> shaped);

    // R4
    hold_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_HOLD) |-> (cnt_q != '0));
endmodule

// File: rtl/ctp_couple.sv
module ctp_couple import ctp_pkg::*; (
    input  logic       sh_even,
    input  logic       sh_odd,
    input  logic [2:0] sel,
    output logic       ctrig
);
    always_comb begin
        case (sel)
            CMB_AND:  ctrig = sh_even & sh_odd;
            CMB_OR:   ctrig = sh_even | sh_odd;
            CMB_EVEN: ctrig = sh_even;
            CMB_ODD:  ctrig = sh_odd;
            default:  ctrig = 1'b0;
        endcase
    end

    // R8
    always_comb begin
        if (ctrig) begin
            ctrig_source_chk: assert (sh_even || sh_odd);
        end
    end
endmodule

// File: rtl/pair_coinc_trigger.sv
module pair_coinc_trigger import ctp_pkg::*; #(
    parameter int NUM_CH  = 16,
    parameter int WIDTH_W = 10,
    parameter int CFG_DW  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         hit_i,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_sel,
    input  logic [$clog2(NUM_CH)-1:0] cfg_idx,
    input  logic [CFG_DW-1:0]         cfg_wdata,
    output logic [NUM_CH-1:0]         acc_o
);
    localparam int NUM_CPL = NUM_CH / 2;
    localparam int IDXW    = $clog2(NUM_CH);
    localparam int CPLW    = IDXW - 1;

    logic [NUM_CH-1:0][1:0]          mode_q;
    logic [NUM_CH-1:0]               dis_q;
    logic [NUM_CH-1:0][WIDTH_W-1:0]  width_q;
    logic [NUM_CPL-1:0][2:0]         comb_q;
    logic [NUM_CPL-1:0][2:0]         vsrc_q;
    logic [NUM_CPL-1:0][NUM_CPL-1:0] mask_q;

    logic [NUM_CH-1:0]  fire, shaped, val;
    logic [NUM_CPL-1:0] ctrig, masked;
    logic [NUM_CH-1:0]  acc_q;
    logic               any_ct;
    logic [CPLW-1:0]    cpl_idx;

    assign cpl_idx = cfg_idx[IDXW-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dis_q   <= '0;
            width_q <= '0;
            comb_q  <= '0;
            vsrc_q  <= '0;
            mask_q  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_CTRL: begin
                    mode_q[cfg_idx] <= cfg_wdata[1:0];
                    dis_q[cfg_idx]  <= cfg_wdata[2];
                end
                SEL_WIDTH: width_q[cfg_idx] <= cfg_wdata[WIDTH_W-1:0];
                SEL_CPL: begin
                    comb_q[cpl_idx] <= cfg_wdata[2:0];
                    vsrc_q[cpl_idx] <= cfg_wdata[6:4];
                end
                SEL_MASK: mask_q[cpl_idx] <= cfg_wdata[NUM_CPL-1:0];
            endcase
        end
    end

    assign any_ct = |ctrig;

    for (genvar c = 0; c < NUM_CPL; c++) begin : g_cpl
        ctp_couple u_cpl (
            .sh_even (shaped[2*c]),
            .sh_odd  (shaped[2*c+1]),
            .sel     (comb_q[c]),
            .ctrig   (ctrig[c])
        );
        assign masked[c] = |(mask_q[c] & ctrig);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int CP = i / 2;
        localparam int PT = i ^ 1;

        assign fire[i] = hit_i[i] & ~dis_q[i];

        ctp_shaper #(.WIDTH_W(WIDTH_W)) u_shp (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire   (fire[i]),
            .width  (width_q[i]),
            .shaped (shaped[i])
        );

        always_comb begin
            case (vsrc_q[CP])
                VAL_PARTNER: val[i] = shaped[PT];
                VAL_MASK:    val[i] = masked[CP];
                VAL_ANY:     val[i] = any_ct;
                default:     val[i] = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) acc_q[i] <= 1'b0;
            else        acc_q[i] <= fire[i] & ((mode_q[i] != MODE_COINC) | val[i]);
        end

        // R3
        acc_needs_enabled_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            acc_q[i] |-> ($past(hit_i[i]) && !$past(dis_q[i])));

        // R6
        coinc_needs_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_q[i] && $past(mode_q[i]) == MODE_COINC) |-> $past(val[i]));

        // R10
        width_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == SEL_WIDTH && cfg_idx == IDXW'(i))
            |=> (width_q[i] == $past(cfg_wdata[WIDTH_W-1:0])));
    end

    assign acc_o = acc_q;
endmodule

// File: tb/sim_pair_coinc_trigger.sv
module sim_pair_coinc_trigger;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] hit;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [1:0] cfg_idx;
    logic [15:0] cfg_wdata;
    logic [3:0] acc;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pair_coinc_trigger #(.NUM_CH(4), .WIDTH_W(10), .CFG_DW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_o(acc)
    );

    task automatic chk(input string req, input logic [3:0] exp);
        checks++;
        if (acc !== exp) begin
            errors++;
            $display("FAIL %s: acc=%b expected %b", req, acc, exp);
        end
    endtask

    // drive one cycle of hits; on return acc shows the result for them
    task automatic step(input logic [3:0] h);
        hit = h;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(4'b0000);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [1:0] idx, input logic [15:0] d);
        hit = 4'b0000; cfg_we = 1'b1; cfg_sel = s; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // ch0 fires, ch2 fires "gap" cycles later; returns acc of the ch2 cycle
    task automatic pair_probe(input logic [3:0] first, input int gap, input logic [3:0] second,
                              input string req, input logic [3:0] exp);
        step(first);
        idle(gap - 1);
        step(second);
        chk(req, exp);
        idle(8);
    endtask

    task automatic t_reset;
        chk("R1 reset accepts low", 4'b0000);
        step(4'b1111); chk("R1 R2 default free mode accepts all", 4'b1111);
        step(4'b0000); chk("R2 accept lasts one cycle", 4'b0000);
        idle(4);
    endtask

    task automatic t_disable;
        cfg_write(2'd0, 2'd0, 16'h0001);   // ch0 coincidence
        cfg_write(2'd0, 2'd1, 16'h0004);   // ch1 disabled
        step(4'b0011); chk("R3 disabled partner neither accepts nor validates", 4'b0000);
        idle(2);
        cfg_write(2'd0, 2'd1, 16'h0000);
        step(4'b0011); chk("R6 same-cycle partner validates", 4'b0011);
        idle(2);
        cfg_write(2'd0, 2'd0, 16'h0000);
        idle(4);
    endtask

    task automatic t_window;
        cfg_write(2'd0, 2'd1, 16'h0001);   // ch1 coincidence, partner validation
        cfg_write(2'd1, 2'd0, 16'd5);      // ch0 width 5
        step(4'b0010); chk("R6 lone coincidence hit rejected", 4'b0000);
        idle(2);
        pair_probe(4'b0001, 4, 4'b0010, "R4 last window cycle validates", 4'b0010);
        pair_probe(4'b0001, 5, 4'b0010, "R4 window closed after W ticks", 4'b0000);
        cfg_write(2'd1, 2'd0, 16'd0);
        pair_probe(4'b0001, 1, 4'b0010, "R4 width 0 has no stretch", 4'b0000);
        step(4'b0011); chk("R4 width 0 active in hit cycle", 4'b0011);
        idle(4);
    endtask

    task automatic t_retrigger;
        cfg_write(2'd1, 2'd0, 16'd5);
        step(4'b0001); idle(2); step(4'b0001); idle(3); step(4'b0010);
        chk("R5 retrigger extends window", 4'b0010);
        idle(8);
        step(4'b0001); idle(2); step(4'b0001); idle(4); step(4'b0010);
        chk("R5 extended window ends", 4'b0000);
        idle(8);
        step(4'b0001);
        cfg_write(2'd1, 2'd0, 16'd1);      // width write during a running stretch
        idle(2); step(4'b0010);
        chk("R5 R10 running stretch not truncated", 4'b0010);
        idle(8);
        pair_probe(4'b0001, 1, 4'b0010, "R10 new width used by next hit", 4'b0000);
        cfg_write(2'd0, 2'd1, 16'h0000);
    endtask

    task automatic t_couples;
        cfg_write(2'd1, 2'd0, 16'd4);
        cfg_write(2'd1, 2'd1, 16'd4);
        cfg_write(2'd0, 2'd2, 16'h0001);   // ch2 coincidence
        cfg_write(2'd2, 2'd2, 16'h0050);   // couple1: AND combine, mask validation
        cfg_write(2'd3, 2'd2, 16'h0001);   // couple1 mask: couple0
        cfg_write(2'd2, 2'd0, 16'h0000);   // couple0: AND
        idle(2);
        pair_probe(4'b0001, 2, 4'b0100, "R8 AND needs both channels", 4'b0000);
        pair_probe(4'b0011, 2, 4'b0100, "R8 R9 AND couple validates via mask", 4'b0100);
        cfg_write(2'd2, 2'd0, 16'h0005);
        pair_probe(4'b0010, 2, 4'b0100, "R8 even-only ignores odd", 4'b0000);
        pair_probe(4'b0001, 2, 4'b0100, "R8 even-only passes even", 4'b0100);
        cfg_write(2'd2, 2'd0, 16'h0006);
        pair_probe(4'b0001, 2, 4'b0100, "R8 odd-only ignores even", 4'b0000);
        pair_probe(4'b0010, 2, 4'b0100, "R8 odd-only passes odd", 4'b0100);
        cfg_write(2'd2, 2'd0, 16'h0003);
        pair_probe(4'b0011, 2, 4'b0100, "R8 unused combine code gives nothing", 4'b0000);
        cfg_write(2'd2, 2'd0, 16'h0001);
        pair_probe(4'b0001, 2, 4'b0100, "R8 OR combine", 4'b0100);
        cfg_write(2'd3, 2'd2, 16'h0000);
        pair_probe(4'b0001, 2, 4'b0100, "R9 cleared mask bit blocks", 4'b0000);
        cfg_write(2'd3, 2'd2, 16'h0002);   // couple1 validated by itself
        step(4'b0100); chk("R9 own couple AND not met", 4'b0000);
        idle(4);
        step(4'b1100); chk("R9 own couple via mask", 4'b1100);
        idle(6);
        cfg_write(2'd2, 2'd2, 16'h0070);   // any-couple validation
        pair_probe(4'b0010, 2, 4'b0100, "R7 any-couple OR validates", 4'b0100);
        cfg_write(2'd2, 2'd0, 16'h0000);
        pair_probe(4'b0010, 2, 4'b0100, "R7 any-couple with silent couples", 4'b0000);
        cfg_write(2'd2, 2'd2, 16'h0020);   // unused validation code
        cfg_write(2'd2, 2'd0, 16'h0001);
        pair_probe(4'b0011, 2, 4'b0100, "R7 unused source gives no validation", 4'b0000);
        cfg_write(2'd2, 2'd2, 16'h0000);   // partner validation
        step(4'b1100); chk("R7 partner source within couple", 4'b1100);
        idle(4);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: acc=%b expected run completion", acc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        hit = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disable();
        t_window();
        t_retrigger();
        t_couples();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule